// File: doc/BRIEF.md
# Shared Debug Pin Controller

This block drives a 16-pin debug port. Each pin can follow a hardware status signal or be driven from software. Software-driven pins can act as outputs or as inputs. One output register is held inside the block. Two CPUs reach it through two identical register ports, and each port can set or clear single bits of that register without a read-modify-write. The last write to a bit decides its level.

Each port can also write the per-pin source select and the per-pin direction, and can read back the stored values. It can read the level of every pin too. Pad input levels cross into the clock domain through a two-stage synchroniser before any read can see them. Each pin leaves the block as a level and an output enable, and the pad cell itself lies outside the block.

After reset, pins 15 to 12 are software outputs driven low and pins 11 to 0 follow their hardware status signals. Register offsets inside a port are: 0 set-bits, 1 clear-bits, 2 source select, 3 direction, 4 pin levels (read only), 5 output register (read only). Offsets 6 and 7, and any address with bits above bit 2 set, are unmapped.

Top module: `dbgio_ctrl`

## Requirements
- R1: After reset the source-select register reads 0xF000, the direction register reads 0xFFFF and the output register reads 0x0000. Every pin has its output enable high.
- R2: A write to offset 0 (set-bits) from either port sets the output-register bits where the write data is 1. Bits where the data is 0 keep their value.
- R3: A write to offset 1 (clear-bits) from either port clears the output-register bits where the write data is 1. Bits where the data is 0 keep their value.
- R4: When both ports change the output register in the same cycle, the result is as if port 1's change came first and port 0's change came after it. A clear from port 0 therefore beats everything else, and a set from port 0 beats anything from port 1.
- R5: A pin whose source bit is 0 drives its hardware status level with the output enable high, whatever its direction bit and output-register bit hold.
- R6: A pin whose source bit is 1 drives its output-register bit. Its output enable equals its direction bit, where 1 means output.
- R7: A pin whose source bit is 1 and whose direction bit is 0 has its output enable low, so the level comes from outside.
- R8: A read of offset 4 returns pad levels through a two-flop synchroniser. A pad change that is present before rising edge k shows up in a read sampled at edge k+2, but not in a read sampled at edge k+1.
- R9: A write to offset 2 or 3 from either port replaces the whole source or direction register, and a read returns the stored value. If both ports write the same one of these registers in the same cycle, port 0's data is kept.
- R10: A read of offset 5 returns the current output register from either port.
- R11: Reads of offsets 0, 1, 6 and 7 return zero. Writes to offsets 4 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu0_wr_en | input | 1 | Port 0 write strobe |
| cpu0_rd_en | input | 1 | Port 0 read strobe; data is valid after the next rising edge |
| cpu0_addr | input | 3 | Port 0 register offset |
| cpu0_wdata | input | 16 | Port 0 write data |
| cpu0_rdata | output | 16 | Port 0 registered read data |
| cpu1_wr_en | input | 1 | Port 1 write strobe |
| cpu1_rd_en | input | 1 | Port 1 read strobe |
| cpu1_addr | input | 3 | Port 1 register offset |
| cpu1_wdata | input | 16 | Port 1 write data |
| cpu1_rdata | output | 16 | Port 1 registered read data |
| hw_status | input | 16 | Hardware status level for each pin |
| pin_in | input | 16 | Level seen at each pad |
| pin_out | output | 16 | Level driven to each pad |
| pin_oe | output | 16 | Output enable for each pad |

## Verification
Set and clear writes are sent alone from each port, and then in pairs in the same cycle. These pairs show whether the priority between ports works, and whether it is wrongly replaced by a plain OR or by a port 1 win. Writes that touch bits of hardware-sourced pins show that those pins ignore the register. Flipping direction bits on hardware pins shows that the direction bit is ignored there. The pad is modelled so that an input pin takes a level the register does not hold. This separates a real readback of the pad from an echo of the output register. Two back-to-back reads around a pad change pin down the exact synchroniser depth.

// File: rtl/dbgio_pkg.sv
package dbgio_pkg;
   localparam int unsigned NUM_CPU = 2;
   localparam int unsigned OFS_W   = 3;

   typedef enum logic [OFS_W-1:0] {
      OFS_SET  = 3'd0,
      OFS_CLR  = 3'd1,
      OFS_SRC  = 3'd2,
      OFS_DIR  = 3'd3,
      OFS_PINS = 3'd4,
      OFS_OUT  = 3'd5
   } dbgio_ofs_e;
endpackage

// File: rtl/dbgio_regport.sv
module dbgio_regport
   import dbgio_pkg::*;
#(
   parameter int unsigned N  = 16,
   parameter int unsigned AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [N-1:0]  wdata,
   input  logic [N-1:0]  src_q,
   input  logic [N-1:0]  dir_q,
   input  logic [N-1:0]  out_q,
   input  logic [N-1:0]  pins_sync,
   output logic [N-1:0]  set_mask,
   output logic [N-1:0]  clr_mask,
   output logic          src_we,
   output logic          dir_we,
   output logic [N-1:0]  rdata
);
   logic             in_page;
   logic [OFS_W-1:0] ofs;
   logic [N-1:0]     rd_next;

   assign in_page = ((addr >> OFS_W) == '0);
   assign ofs     = addr[OFS_W-1:0];

   // write decode: set/clear masks are gated to zero unless addressed
   assign set_mask = (wr_en && in_page && ofs == OFS_SET) ? wdata : '0;
   assign clr_mask = (wr_en && in_page && ofs == OFS_CLR) ? wdata : '0;
   assign src_we   = wr_en && in_page && (ofs == OFS_SRC);
   assign dir_we   = wr_en && in_page && (ofs == OFS_DIR);

   always_comb begin
      rd_next = '0;
      if (in_page) begin
         case (ofs)
            OFS_SRC:  rd_next = src_q;
            OFS_DIR:  rd_next = dir_q;
            OFS_PINS: rd_next = pins_sync;
            OFS_OUT:  rd_next = out_q;
            default:  rd_next = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         rdata <= rd_next;
      end
   end
endmodule

// File: rtl/dbgio_store.sv
module dbgio_store #(
   parameter int unsigned    N       = 16,
   parameter int unsigned    NC      = 2,
   parameter logic [N-1:0]   SRC_RST = '0,
   parameter logic [N-1:0]   DIR_RST = '1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NC-1:0][N-1:0]  set_mask,
   input  logic [NC-1:0][N-1:0]  clr_mask,
   input  logic [NC-1:0][N-1:0]  wdata,
   input  logic [NC-1:0]         src_we,
   input  logic [NC-1:0]         dir_we,
   output logic [N-1:0]          src_q,
   output logic [N-1:0]          dir_q,
   output logic [N-1:0]          out_q
);
   logic [N-1:0] out_n, src_n, dir_n;

   // Highest-numbered port is applied first; port 0 is applied last and wins.
   always_comb begin
      out_n = out_q;
      src_n = src_q;
      dir_n = dir_q;
      for (int c = int'(NC) - 1; c >= 0; c--) begin
         out_n = (out_n | set_mask[c]) & ~clr_mask[c];
         if (src_we[c]) src_n = wdata[c];
         if (dir_we[c]) dir_n = wdata[c];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q <= '0;
         src_q <= SRC_RST;
         dir_q <= DIR_RST;
      end else begin
         out_q <= out_n;
         src_q <= src_n;
         dir_q <= dir_n;
      end
   end
endmodule

// File: rtl/dbgio_sync.sv
module dbgio_sync #(
   parameter int unsigned N      = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   logic [STAGES-1:0][N-1:0] stg;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dbgio_pinmux.sv
module dbgio_pinmux #(
   parameter int unsigned N = 16
) (
   input  logic [N-1:0] src_q,
   input  logic [N-1:0] dir_q,
   input  logic [N-1:0] out_q,
   input  logic [N-1:0] hw_status,
   output logic [N-1:0] pin_out,
   output logic [N-1:0] pin_oe
);
   for (genvar i = 0; i < N; i++) begin : g_pin
      // hardware-sourced pins are always driven; direction only matters for software pins
      assign pin_out[i] = src_q[i] ? out_q[i] : hw_status[i];
      assign pin_oe[i]  = src_q[i] ? dir_q[i] : 1'b1;
   end
endmodule

// File: rtl/dbgio_ctrl.sv
module dbgio_ctrl
   import dbgio_pkg::*;
#(
   parameter int unsigned NUM_PINS     = 16,
   parameter int unsigned ADDR_W       = 3,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned SW_PINS_RST  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu0_wr_en,
   input  logic                cpu0_rd_en,
   input  logic [ADDR_W-1:0]   cpu0_addr,
   input  logic [NUM_PINS-1:0] cpu0_wdata,
   output logic [NUM_PINS-1:0] cpu0_rdata,
   input  logic                cpu1_wr_en,
   input  logic                cpu1_rd_en,
   input  logic [ADDR_W-1:0]   cpu1_addr,
   input  logic [NUM_PINS-1:0] cpu1_wdata,
   output logic [NUM_PINS-1:0] cpu1_rdata,
   input  logic [NUM_PINS-1:0] hw_status,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe
);
   localparam logic [NUM_PINS-1:0] SRC_RST = {NUM_PINS{1'b1}} << (NUM_PINS - SW_PINS_RST);
   localparam logic [NUM_PINS-1:0] DIR_RST = {NUM_PINS{1'b1}};

   if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_pins
      $error("dbgio_ctrl: NUM_PINS must lie in 1..32");
   end
   if (ADDR_W < OFS_W) begin : g_bad_addr
      $error("dbgio_ctrl: ADDR_W too narrow for the register offsets");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dbgio_ctrl: SYNC_STAGES must be at least 2");
   end
   if (SW_PINS_RST > NUM_PINS) begin : g_bad_rst
      $error("dbgio_ctrl: SW_PINS_RST exceeds NUM_PINS");
   end

   logic [NUM_CPU-1:0]               wr_en_a, rd_en_a, src_we_a, dir_we_a;
   logic [NUM_CPU-1:0][ADDR_W-1:0]   addr_a;
   logic [NUM_CPU-1:0][NUM_PINS-1:0] wdata_a, rdata_a, set_a, clr_a;
   logic [NUM_PINS-1:0]              src_q, dir_q, out_q, pins_sync;

   assign wr_en_a = {cpu1_wr_en, cpu0_wr_en};
   assign rd_en_a = {cpu1_rd_en, cpu0_rd_en};
   assign addr_a  = {cpu1_addr, cpu0_addr};
   assign wdata_a = {cpu1_wdata, cpu0_wdata};
   assign cpu0_rdata = rdata_a[0];
   assign cpu1_rdata = rdata_a[1];

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_port
      dbgio_regport #(.N(NUM_PINS), .AW(ADDR_W)) u_port (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_en_a[c]),
         .rd_en     (rd_en_a[c]),
         .addr      (addr_a[c]),
         .wdata     (wdata_a[c]),
         .src_q     (src_q),
         .dir_q     (dir_q),
         .out_q     (out_q),
         .pins_sync (pins_sync),
         .set_mask  (set_a[c]),
         .clr_mask  (clr_a[c]),
         .src_we    (src_we_a[c]),
         .dir_we    (dir_we_a[c]),
         .rdata     (rdata_a[c])
      );
   end

   dbgio_store #(
      .N(NUM_PINS), .NC(NUM_CPU), .SRC_RST(SRC_RST), .DIR_RST(DIR_RST)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (set_a),
      .clr_mask (clr_a),
      .wdata    (wdata_a),
      .src_we   (src_we_a),
      .dir_we   (dir_we_a),
      .src_q    (src_q),
      .dir_q    (dir_q),
      .out_q    (out_q)
   );

   dbgio_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pins_sync)
   );

   dbgio_pinmux #(.N(NUM_PINS)) u_mux (
      .src_q     (src_q),
      .dir_q     (dir_q),
      .out_q     (out_q),
      .hw_status (hw_status),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );
endmodule

// File: rtl/dbgio_chk.sv
module dbgio_chk
   import dbgio_pkg::*;
#(
   parameter int unsigned N  = 16,
   parameter int unsigned AW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr0,
   input logic [AW-1:0] addr0,
   input logic [N-1:0]  wdata0,
   input logic          wr1,
   input logic [N-1:0]  hw_status,
   input logic [N-1:0]  pin_out,
   input logic [N-1:0]  pin_oe,
   input logic [N-1:0]  src_q,
   input logic [N-1:0]  dir_q,
   input logic [N-1:0]  out_q
);
   // R2: port 0 set lands regardless of port 1
   a_r2_p0_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr0 && addr0 == AW'(OFS_SET)) |=> ((out_q & $past(wdata0)) == $past(wdata0)));

   // R3 and R4: port 0 clear wins over anything port 1 does
   a_r3_p0_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr0 && addr0 == AW'(OFS_CLR)) |=> ((out_q & $past(wdata0)) == '0));

   // R5: hardware pins always driven with the status level
   a_r5_hw_oe: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe | src_q) == '1));
   a_r5_hw_level: assert property (@(posedge clk) disable iff (!rst_n)
      (((pin_out ^ hw_status) & ~src_q) == '0));

   // R6: software pins carry the stored register bit
   a_r6_sw_level: assert property (@(posedge clk) disable iff (!rst_n)
      (((pin_out ^ out_q) & src_q) == '0));

   // R7: software inputs release the pad
   a_r7_sw_in_oe: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe & src_q & ~dir_q) == '0));

   // R11: writes to read-only or unmapped offsets change nothing
   a_r11_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr0 && !wr1 && addr0 >= AW'(OFS_PINS)) |=> ($stable(out_q) && $stable(src_q) && $stable(dir_q)));
endmodule

bind dbgio_ctrl dbgio_chk #(.N(NUM_PINS), .AW(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr0       (cpu0_wr_en),
   .addr0     (cpu0_addr),
   .wdata0    (cpu0_wdata),
   .wr1       (cpu1_wr_en),
   .hw_status (hw_status),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .src_q     (src_q),
   .dir_q     (dir_q),
   .out_q     (out_q)
);

// File: tb/tb_dbgio_ctrl.sv
module tb_dbgio_ctrl;
   import dbgio_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        c0_wr = 1'b0, c0_rd = 1'b0, c1_wr = 1'b0, c1_rd = 1'b0;
   logic [2:0]  c0_addr = '0, c1_addr = '0;
   logic [15:0] c0_wd = '0, c1_wd = '0;
   logic [15:0] c0_rdata, c1_rdata;
   logic [15:0] hw_status = '0, ext_drv = '0;
   logic [15:0] pin_in, pin_out, pin_oe;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   typedef struct {
      int          port;
      logic [15:0] exp;
      string       tag;
   } rd_item_t;
   rd_item_t sbq[$];

   always #10 clk = ~clk;

   // pad model: driven pins reflect the block, released pins follow the outside
   assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_drv);

   dbgio_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .cpu0_wr_en(c0_wr), .cpu0_rd_en(c0_rd), .cpu0_addr(c0_addr),
      .cpu0_wdata(c0_wd), .cpu0_rdata(c0_rdata),
      .cpu1_wr_en(c1_wr), .cpu1_rd_en(c1_rd), .cpu1_addr(c1_addr),
      .cpu1_wdata(c1_wd), .cpu1_rdata(c1_rdata),
      .hw_status(hw_status), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic wr(int port, logic [2:0] a, logic [15:0] d);
      if (port == 0) begin c0_wr = 1'b1; c0_addr = a; c0_wd = d; end
      else           begin c1_wr = 1'b1; c1_addr = a; c1_wd = d; end
      @(posedge clk);
      @(negedge clk);
      c0_wr = 1'b0; c1_wr = 1'b0;
   endtask

   task automatic wr2(logic [2:0] a0, logic [15:0] d0, logic [2:0] a1, logic [15:0] d1);
      c0_wr = 1'b1; c0_addr = a0; c0_wd = d0;
      c1_wr = 1'b1; c1_addr = a1; c1_wd = d1;
      @(posedge clk);
      @(negedge clk);
      c0_wr = 1'b0; c1_wr = 1'b0;
   endtask

   // driver: queue the expected value, then issue the read
   task automatic rd(int port, logic [2:0] a, logic [15:0] exp, string tag);
      rd_item_t it;
      it.port = port; it.exp = exp; it.tag = tag;
      sbq.push_back(it);
      if (port == 0) begin c0_rd = 1'b1; c0_addr = a; end
      else           begin c1_rd = 1'b1; c1_addr = a; end
      @(posedge clk);
      @(negedge clk);
      c0_rd = 1'b0; c1_rd = 1'b0;
   endtask

   task automatic pins(string tag, logic [15:0] eo, logic [15:0] eoe);
      check({tag, " pin_out"}, pin_out, eo);
      check({tag, " pin_oe"}, pin_oe, eoe);
   endtask

   // monitor: a read sampled at a rising edge is compared at the following falling edge
   initial begin
      forever begin
         @(posedge clk);
         if (c0_rd || c1_rd) begin
            @(negedge clk);
            if (sbq.size() == 0) begin
               check("scoreboard underflow", 16'h0000, 16'hFFFF);
            end else begin
               rd_item_t it;
               it = sbq.pop_front();
               check(it.tag, (it.port == 0) ? c0_rdata : c1_rdata, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      pins("R1 reset", 16'h0000, 16'hFFFF);
      rd(0, OFS_SRC, 16'hF000, "R1 src reset");
      rd(1, OFS_DIR, 16'hFFFF, "R1 dir reset");
      rd(0, OFS_OUT, 16'h0000, "R1 out reset");

      // R5 hardware pins follow status
      hw_status = 16'hA5C3;
      #1;
      pins("R5 hw follow", 16'h05C3, 16'hFFFF);

      // R2 set from both ports, R5 register bits ignored on hw pins
      wr(0, OFS_SET, 16'h3000);
      pins("R2 p0 set", 16'h35C3, 16'hFFFF);
      wr(1, OFS_SET, 16'h8000);
      pins("R2 p1 set", 16'hB5C3, 16'hFFFF);
      wr(1, OFS_SET, 16'h0004);
      pins("R5 hw ignores reg", 16'hB5C3, 16'hFFFF);
      rd(1, OFS_OUT, 16'hB004, "R10 out readback p1");

      // R3 clear from both ports
      wr(1, OFS_CLR, 16'h1000);
      wr(0, OFS_CLR, 16'h0004);
      rd(0, OFS_OUT, 16'hA000, "R3 clear");
      pins("R3 clear", 16'hA5C3, 16'hFFFF);

      // R4 same-cycle priority
      wr2(OFS_SET, 16'h0F00, OFS_CLR, 16'h0300);
      rd(1, OFS_OUT, 16'hAF00, "R4 p0 set beats p1 clr");
      wr2(OFS_CLR, 16'h0A00, OFS_SET, 16'h0F0F);
      rd(0, OFS_OUT, 16'hA50F, "R4 p0 clr beats p1 set");

      // R7 software input, R8 readback through synchroniser
      ext_drv = 16'h0000;
      wr(0, OFS_DIR, 16'h7FFF);
      pins("R7 sw input", 16'hA5C3, 16'h7FFF);
      repeat (3) @(negedge clk);
      rd(0, OFS_PINS, 16'h25C3, "R8 pad level input low");
      ext_drv = 16'h8000;
      @(negedge clk);
      rd(1, OFS_PINS, 16'h25C3, "R8 too early after change");
      rd(1, OFS_PINS, 16'hA5C3, "R8 visible after two stages");

      // R5 direction ignored on hw pins, R9 dir readback
      ext_drv = 16'h5000;
      wr(1, OFS_DIR, 16'h0000);
      pins("R5 hw dir ignored", 16'hA5C3, 16'h0FFF);
      repeat (3) @(negedge clk);
      rd(1, OFS_PINS, 16'h55C3, "R8 inputs from outside");
      rd(0, OFS_DIR, 16'h0000, "R9 dir readback");

      // R6 software outputs on low pins after source change
      wr(1, OFS_SRC, 16'h000F);
      pins("R7 low pins input", 16'hA5CF, 16'hFFF0);
      wr(0, OFS_DIR, 16'hFFFF);
      pins("R6 sw output", 16'hA5CF, 16'hFFFF);

      // R9 same-cycle source collision
      wr2(OFS_SRC, 16'h00F0, OFS_SRC, 16'h0F00);
      rd(1, OFS_SRC, 16'h00F0, "R9 p0 wins src");
      pins("R9 src applied", 16'hA503, 16'hFFFF);

      // R11 unmapped reads, ignored writes
      rd(0, OFS_SET, 16'h0000, "R11 read set offset");
      rd(1, 3'd7, 16'h0000, "R11 read unmapped");
      wr(0, OFS_PINS, 16'hFFFF);
      wr(1, OFS_OUT, 16'h0000);
      wr(0, 3'd6, 16'h1234);
      rd(0, OFS_OUT, 16'hA50F, "R11 out unchanged");
      rd(1, OFS_SRC, 16'h00F0, "R11 src unchanged");
      rd(0, OFS_DIR, 16'hFFFF, "R11 dir unchanged");

      repeat (2) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule